// File: doc/BRIEF.md
# Burst-Dimming PWM Generator

This block produces the low-frequency enable that switches a lamp inverter's current on and off to set brightness. Each dimming period is split into 256 equal sub-steps, which are grouped in pairs into 128 slices. The enable is high from the start of a period for a number of sub-steps set by a digital brightness level. Low levels are raised to a fixed floor, and any level at full scale or beyond keeps the enable on for the whole period. The block also outputs a slice strobe and a period-start strobe. Other logic, such as an undervoltage timeout, can use these strobes as a timebase.

The sub-step timebase has three sources. A programmable internal divider can step it, or it can step on both edges of an external high-frequency clock. In a third mode the generator is bypassed and an external low-frequency PWM is copied to the output. The brightness level is captured once, at the start of each period. A period therefore never carries a mix of two duty values.

Top module: `dimpwm_gen`

## Requirements
- R1: While `rst_n` is sampled low, `dim_on_o`, `slice_o` and `period_start_o` are low one cycle later. After `rst_n` is released (mode 00), the first `period_start_o` pulse appears on the second clock edge.
- R2: In mode 00, and also in mode 11, a sub-step occurs every `div_i` clock cycles, with a value of 0 treated as 1. One period lasts 256 sub-steps.
- R3: In mode 01, every edge of `ext_clk_i` (rising or falling) is one sub-step. One period therefore equals 128 cycles of the external clock.
- R4: `slice_o` pulses 128 times per period, on every even sub-step. `period_start_o` pulses once per period, in the same cycle as the first slice.
- R5: Levels 0 to 25 all give the enable high for 25 of the 256 sub-steps.
- R6: Levels 26 to 255 give the enable high for exactly that many sub-steps, starting at the period start.
- R7: Levels of 256 or more keep `dim_on_o` continuously high.
- R8: The level is sampled only at the sub-step that starts a period. A change in the middle of a period does not affect that period.
- R9: In mode 10, `dim_on_o` equals `ext_pwm_i` delayed by three clock edges. `level_i` has no effect, and both strobes stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Source: 00 divider, 01 external clock, 10 PWM pass-through, 11 as 00 |
| level_i | input | LEVEL_W (9) | Brightness level, full scale at 256 |
| div_i | input | DIV_W (24) | Clock cycles per sub-step in divider mode |
| ext_clk_i | input | 1 | External high-frequency clock (asynchronous) |
| ext_pwm_i | input | 1 | External low-frequency PWM (asynchronous) |
| dim_on_o | output | 1 | Lamp-current enable |
| slice_o | output | 1 | One-cycle strobe, 128 per period |
| period_start_o | output | 1 | One-cycle strobe at each period start |

## Verification
In the generator modes, the enable and both strobes change one cycle after the clock edge on which a sub-step tick occurs. An external clock edge adds two synchronizer cycles before it becomes that tick. In pass-through mode the output follows its input by three edges, and the reset release reaches the first period start on the second edge. The bench checks those two cases at exactly those edges. Everything else is measured over whole periods, counted from one period-start strobe to the next: enable-high cycles, period length and slice count. Expected values come from the level held on the edge that opened the period, so a fixed latency shift cannot hide or create a mismatch.

// File: rtl/dimpwm_pkg.sv
package dimpwm_pkg;

   // Timebase source select carried on mode_i
   typedef enum logic [1:0] {
      SRC_DIVIDER   = 2'b00,
      SRC_EXT_CLOCK = 2'b01,
      SRC_EXT_PWM   = 2'b10,
      SRC_SPARE     = 2'b11
   } dim_src_e;

endpackage

// File: rtl/dimpwm_sync.sv
module dimpwm_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);

   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 1) begin : g_bad_depth
         $error("dimpwm_sync: STAGES must be at least 1");
      end
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= d_i;
         end
      end else begin : g_chain
         always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[STAGES-2:0], d_i};
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/dimpwm_tick.sv
module dimpwm_tick
   import dimpwm_pkg::*;
#(
   parameter int unsigned DIV_W       = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       mode_i,
   input  logic [DIV_W-1:0] div_i,
   input  logic             ext_clk_i,
   output logic             tick_o
);

   logic             use_div;
   logic             use_ext;
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] div_last;
   logic             div_hit;
   logic             ck_s;
   logic             ck_d_q;
   logic             ck_edge;

   assign use_div = (mode_i == SRC_DIVIDER) || (mode_i == SRC_SPARE);
   assign use_ext = (mode_i == SRC_EXT_CLOCK);

   // Divider: terminal count is div_i-1, a zero ratio behaves as one
   assign div_last = (div_i == '0) ? '0 : (div_i - DIV_W'(1));
   assign div_hit  = (cnt_q >= div_last);

   always_ff @(posedge clk) begin
      if (!rst_n || !use_div) cnt_q <= '0;
      else if (div_hit)       cnt_q <= '0;
      else                    cnt_q <= cnt_q + DIV_W'(1);
   end

   // External clock: both edges count as sub-steps
   dimpwm_sync #(.STAGES(SYNC_STAGES)) ck_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_clk_i),
      .q_o   (ck_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) ck_d_q <= 1'b0;
      else        ck_d_q <= ck_s;
   end

   assign ck_edge = ck_s ^ ck_d_q;

   assign tick_o = (use_div && div_hit) || (use_ext && ck_edge);

endmodule

// File: rtl/dimpwm_phase.sv
module dimpwm_phase #(
   parameter int unsigned PHASE_W     = 8,
   parameter int unsigned LEVEL_W     = 9,
   parameter int unsigned MIN_LEVEL   = 25,
   parameter int unsigned SLICE_SHIFT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_i,
   input  logic [LEVEL_W-1:0] level_i,
   output logic               chop_o,
   output logic               slice_o,
   output logic               start_o
);

   localparam int unsigned   STEPS    = 1 << PHASE_W;
   localparam logic [PHASE_W:0] FULL_THR = (PHASE_W+1)'(STEPS);
   localparam logic [PHASE_W:0] MIN_THR  = (PHASE_W+1)'(MIN_LEVEL);

   generate
      if (LEVEL_W <= PHASE_W) begin : g_bad_level
         $error("dimpwm_phase: LEVEL_W must exceed PHASE_W to reach full scale");
      end
      if (MIN_LEVEL >= STEPS) begin : g_bad_floor
         $error("dimpwm_phase: MIN_LEVEL must be below the step count");
      end
      if (SLICE_SHIFT > PHASE_W) begin : g_bad_slice
         $error("dimpwm_phase: SLICE_SHIFT exceeds PHASE_W");
      end
   endgenerate

   logic [PHASE_W-1:0] ph_q;
   logic [PHASE_W-1:0] ph_n;
   logic [PHASE_W:0]   thr_q;
   logic [PHASE_W:0]   lvl_thr;
   logic [PHASE_W:0]   thr_use;
   logic               wrap;
   logic               slice_hit;

   assign wrap = (ph_q == {PHASE_W{1'b1}});
   assign ph_n = ph_q + PHASE_W'(1);

   // Level to on-steps: floor at the bottom, saturate at full scale
   always_comb begin
      if (level_i >= LEVEL_W'(STEPS))          lvl_thr = FULL_THR;
      else if (level_i < LEVEL_W'(MIN_LEVEL))  lvl_thr = MIN_THR;
      else                                     lvl_thr = level_i[PHASE_W:0];
   end

   // A new level only takes effect on the step that opens a period
   assign thr_use = wrap ? lvl_thr : thr_q;

   generate
      if (SLICE_SHIFT == 0) begin : g_slice_every
         assign slice_hit = 1'b1;
      end else begin : g_slice_grouped
         assign slice_hit = (ph_n[SLICE_SHIFT-1:0] == '0);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= {PHASE_W{1'b1}};
         thr_q   <= '0;
         chop_o  <= 1'b0;
         slice_o <= 1'b0;
         start_o <= 1'b0;
      end else if (tick_i) begin
         ph_q    <= ph_n;
         if (wrap) thr_q <= lvl_thr;
         chop_o  <= ({1'b0, ph_n} < thr_use);
         slice_o <= slice_hit;
         start_o <= wrap;
      end else begin
         slice_o <= 1'b0;
         start_o <= 1'b0;
      end
   end

endmodule

// File: rtl/dimpwm_gen.sv
module dimpwm_gen
   import dimpwm_pkg::*;
#(
   parameter int unsigned LEVEL_W     = 9,
   parameter int unsigned PHASE_W     = 8,
   parameter int unsigned SLICE_SHIFT = 1,
   parameter int unsigned MIN_LEVEL   = 25,
   parameter int unsigned DIV_W       = 24,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [1:0]         mode_i,
   input  logic [LEVEL_W-1:0] level_i,
   input  logic [DIV_W-1:0]   div_i,
   input  logic               ext_clk_i,
   input  logic               ext_pwm_i,
   output logic               dim_on_o,
   output logic               slice_o,
   output logic               period_start_o
);

   generate
      if (DIV_W < 1) begin : g_bad_div
         $error("dimpwm_gen: DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("dimpwm_gen: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic tick;
   logic chop;
   logic pwm_s;
   logic pass_q;
   logic pass_sel;

   dimpwm_tick #(
      .DIV_W       (DIV_W),
      .SYNC_STAGES (SYNC_STAGES)
   ) tick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .mode_i    (mode_i),
      .div_i     (div_i),
      .ext_clk_i (ext_clk_i),
      .tick_o    (tick)
   );

   dimpwm_phase #(
      .PHASE_W     (PHASE_W),
      .LEVEL_W     (LEVEL_W),
      .MIN_LEVEL   (MIN_LEVEL),
      .SLICE_SHIFT (SLICE_SHIFT)
   ) phase_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick),
      .level_i (level_i),
      .chop_o  (chop),
      .slice_o (slice_o),
      .start_o (period_start_o)
   );

   // Pass-through path for an external dimming waveform
   dimpwm_sync #(.STAGES(SYNC_STAGES)) pwm_sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (ext_pwm_i),
      .q_o   (pwm_s)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pass_q <= 1'b0;
      else        pass_q <= pwm_s;
   end

   assign pass_sel = (mode_i == SRC_EXT_PWM);
   assign dim_on_o = pass_sel ? pass_q : chop;

endmodule

// File: rtl/dimpwm_gen_chk.sv
module dimpwm_gen_chk
   import dimpwm_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned SLICE_SHIFT = 1
) (
   input logic       clk,
   input logic       rst_n,
   input logic [1:0] mode_i,
   input logic       ext_pwm_i,
   input logic       dim_on_o,
   input logic       slice_o,
   input logic       period_start_o
);

   // R1: reset silences every output on the following cycle
   a_r1_reset_quiet: assert property (@(posedge clk)
      !rst_n |=> (!dim_on_o && !slice_o && !period_start_o));

   // R4: the period start coincides with a slice strobe
   a_r4_start_on_slice: assert property (@(posedge clk) disable iff (!rst_n)
      period_start_o |-> slice_o);

   generate
      if (SLICE_SHIFT >= 1) begin : g_slice_gap
         // R4: slices are single-cycle and never back to back
         a_r4_slice_single: assert property (@(posedge clk) disable iff (!rst_n)
            slice_o |=> !slice_o);
      end
      if (SYNC_STAGES == 2) begin : g_pass_delay
         // R9: pass-through output lags the external waveform by three edges
         a_r9_pass_delay: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_i == SRC_EXT_PWM && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
            |-> (dim_on_o == $past(ext_pwm_i, 3)));
      end
   endgenerate

   // R5: every generated period opens with the enable on (floor is nonzero)
   a_r5_start_lit: assert property (@(posedge clk) disable iff (!rst_n)
      (period_start_o && mode_i != SRC_EXT_PWM) |-> dim_on_o);

   // R9: strobes stay low once pass-through has been held
   a_r9_pass_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == SRC_EXT_PWM && $past(mode_i) == SRC_EXT_PWM)
      |-> (!slice_o && !period_start_o));

endmodule

bind dimpwm_gen dimpwm_gen_chk #(
   .SYNC_STAGES (SYNC_STAGES),
   .SLICE_SHIFT (SLICE_SHIFT)
) chk_i (
   .clk            (clk),
   .rst_n          (rst_n),
   .mode_i         (mode_i),
   .ext_pwm_i      (ext_pwm_i),
   .dim_on_o       (dim_on_o),
   .slice_o        (slice_o),
   .period_start_o (period_start_o)
);

// File: tb/dimpwm_gen_tb_top.sv
`timescale 1ns/1ps
module dimpwm_gen_tb_top;

   localparam int LW = 9;
   localparam int DW = 24;

   typedef struct {
      int    hi;
      int    len;
      string tag_hi;
      string tag_len;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = 2'b00;
   logic [LW-1:0] level_i = '0;
   logic [DW-1:0] div_i = DW'(2);
   logic          ext_clk_i = 1'b0;
   logic          ext_pwm_i = 1'b0;
   logic          dim_on_o;
   logic          slice_o;
   logic          period_start_o;

   int   tests = 0;
   int   fails = 0;
   bit   done = 0;
   bit   chk_en = 0;
   int   unit = 2;
   exp_t sb_q[$];

   always #2 clk = ~clk;

   dimpwm_gen dut_i (
      .clk            (clk),
      .rst_n          (rst_n),
      .mode_i         (mode_i),
      .level_i        (level_i),
      .div_i          (div_i),
      .ext_clk_i      (ext_clk_i),
      .ext_pwm_i      (ext_pwm_i),
      .dim_on_o       (dim_on_o),
      .slice_o        (slice_o),
      .period_start_o (period_start_o)
   );

   task automatic check(input string tag, input int act, input int exp_v);
      tests++;
      if (act != exp_v) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
      end
   endtask

   // Expected on-steps for a level: floor 25, full scale 256
   function automatic int on_steps(input int lvl);
      if (lvl >= 256) return 256;
      if (lvl < 25)   return 25;
      return lvl;
   endfunction

   function automatic exp_t predict(input int lvl);
      exp_t e;
      e.hi      = on_steps(lvl) * unit;
      e.len     = 256 * unit;
      e.tag_hi  = (lvl >= 256) ? "R7/R8 on-time" : (lvl <= 25) ? "R5/R8 on-time" : "R6/R8 on-time";
      e.tag_len = (mode_i == 2'b01) ? "R3 period" : "R2 period";
      return e;
   endfunction

   // External high-frequency clock: toggles every 3 system cycles
   initial begin
      int k;
      k = 0;
      forever begin
         @(negedge clk);
         k++;
         if (k == 3) begin
            k = 0;
            ext_clk_i = ~ext_clk_i;
         end
      end
   end

   // Level held on the edge that opens a period (R8 sampling point)
   logic [LW-1:0] lvl_at_edge;
   always @(posedge clk) lvl_at_edge <= level_i;

   // Scoreboard monitor: one expected item per period, compared at its end
   int hi_cnt = 0;
   int len_cnt = 0;
   int sl_cnt = 0;
   bit have = 0;
   always @(negedge clk) begin
      if (!rst_n) begin
         have = 0;
         sb_q.delete();
      end else begin
         if (period_start_o) begin
            if (have && chk_en && sb_q.size() > 0) begin
               exp_t e;
               e = sb_q.pop_front();
               check(e.tag_hi, hi_cnt, e.hi);
               check(e.tag_len, len_cnt, e.len);
               check("R4 slices per period", sl_cnt, 128);
            end
            if (!chk_en) sb_q.delete();
            have = chk_en;
            if (chk_en) sb_q.push_back(predict(int'(lvl_at_edge)));
            hi_cnt  = 0;
            len_cnt = 0;
            sl_cnt  = 0;
         end
         hi_cnt  += int'(dim_on_o);
         len_cnt += 1;
         sl_cnt  += int'(slice_o);
      end
   end

   task automatic wait_start();
      do @(negedge clk); while (!period_start_o);
      #1;
   endtask

   task automatic mid_change(input int lvl);
      wait_start();
      repeat (37) @(negedge clk);
      #1 level_i = LW'(lvl);
   endtask

   initial begin
      int codes[7] = '{0, 25, 26, 100, 255, 256, 400};
      int n;
      int sl;

      repeat (5) @(negedge clk);
      check("R1 reset dim_on", int'(dim_on_o), 0);
      check("R1 reset slice", int'(slice_o), 0);
      check("R1 reset start", int'(period_start_o), 0);
      #1 rst_n = 1'b1;

      // Divider mode, levels across floor, linear range and full scale
      wait_start();
      chk_en = 1;
      foreach (codes[i]) begin
         mid_change(codes[i]);   // R8: change lands mid-period
         wait_start();
         wait_start();
      end

      // Spare mode code behaves as divider, ratio 3
      wait_start();
      chk_en = 0; mode_i = 2'b11; div_i = DW'(3); unit = 3; level_i = LW'(60);
      wait_start(); wait_start();
      chk_en = 1;
      wait_start(); wait_start(); wait_start();

      // External clock mode: both edges step, 3-cycle half period
      chk_en = 0; mode_i = 2'b01; level_i = LW'(30);
      wait_start(); wait_start();
      chk_en = 1;
      wait_start(); wait_start(); wait_start();
      mid_change(256);
      wait_start(); wait_start();

      // Pass-through: level ignored, strobes quiet, three-edge latency (R9)
      chk_en = 0; mode_i = 2'b10; level_i = LW'(300); ext_pwm_i = 1'b0;
      repeat (6) @(negedge clk);
      sl = 0;
      for (int c = 0; c < 40; c++) begin
         @(negedge clk);
         sl += int'(slice_o) + int'(period_start_o);
      end
      check("R9 strobes in pass-through", sl, 0);
      check("R9 output low with input low", int'(dim_on_o), 0);
      #1 ext_pwm_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 rise not before third edge", int'(dim_on_o), 0);
      @(negedge clk);
      check("R9 rise at third edge", int'(dim_on_o), 1);
      #1 level_i = LW'(0);
      repeat (4) @(negedge clk);
      check("R9 level ignored", int'(dim_on_o), 1);
      #1 ext_pwm_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R9 fall not before third edge", int'(dim_on_o), 1);
      @(negedge clk);
      check("R9 fall at third edge", int'(dim_on_o), 0);

      // Full scale then reset mid-run
      #1 mode_i = 2'b00; div_i = DW'(2); unit = 2; level_i = LW'(256);
      wait_start(); wait_start();
      repeat (10) @(negedge clk);
      check("R7 continuously on", int'(dim_on_o), 1);
      chk_en = 1;
      #1 rst_n = 1'b0;
      @(negedge clk);
      check("R1 reset drops dim_on", int'(dim_on_o), 0);
      check("R1 reset drops slice", int'(slice_o), 0);
      #1 rst_n = 1'b1;
      n = 0;
      do begin @(negedge clk); n++; end while (!period_start_o);
      check("R1 first start after release", n, 2);
      #1;
      wait_start(); wait_start();

      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule